// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural register state of a 32-bit processor core. Sixteen logical register indices, a current status word and one saved status word are resolved onto 37 physical 32-bit registers: 31 general-purpose entries and 6 status entries. The physical entry behind each index depends on the operating mode, which lives in the low five bits of the current status word. The fast-interrupt mode has private copies of indices 8 to 14. The normal-interrupt, supervisor, abort and undefined modes have private copies only of index 13 (stack pointer) and index 14 (link register). Every mode other than user and system has its own saved status word.

The file has two combinational read ports and one synchronous write port, all addressed by a 4-bit logical index. A link-capture strobe copies the program counter (index 15) into the link register of the current bank. An exception-entry strobe saves the current status word into the target mode's saved status register and switches the mode in the same clock edge. A compressed-instruction state input sets the program counter alignment. While that input is high, indices 8 to 12 can be reached only when a hi-register access qualifier accompanies the access.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x00000013 (supervisor), every index in every mode reads zero, and the saved status word reads zero.
- R2: Indices 0 to 7 and index 15 name the same physical registers in all modes, so a value written in one mode reads back in every other mode.
- R3: In fast-interrupt mode (mode code 10001), indices 8 to 14 select private copies. Writes there leave the other modes' values untouched.
- R4: In normal-interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes, indices 13 and 14 select a private copy per mode, and indices 8 to 12 select the shared copies.
- R5: User (10000) and system (11111) modes use the same physical registers, and any mode code not listed here behaves as user. In these modes the saved status port reads zero.
- R6: A read of index 15 returns the stored program counter with bits [1:0] cleared when narrow_i is 0, and with only bit 0 cleared when narrow_i is 1.
- R7: A write to index 15 stores the data with bits [1:0] cleared when narrow_i is 0, and with bit 0 cleared when narrow_i is 1.
- R8: A link_en strobe copies the aligned program counter into index 14 of the current mode's bank at the next edge. If the same cycle also writes index 14, the copied program counter wins. A same-cycle write to any other index still takes place.
- R9: An exc_en strobe stores the current status word into the saved status register of the mode given by exc_mode, and replaces the status mode field with exc_mode at the same edge. From the next cycle, reads use the new mode's bank.
- R10: While narrow_i is 1 and hi_access_i is 0, reads of indices 8 to 12 return zero and writes to them are ignored. Indices 0 to 7 and 13 to 15 stay accessible.
- R11: A read of the index being written in the same cycle returns the value held before the write. There is no bypass.
- R12: stat_we replaces the whole status word at the next edge. If exc_en is high in the same cycle, exception entry takes precedence and the stat_we data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| narrow_i | input | 1 | Compressed-instruction state: 1 selects halfword program counter alignment |
| hi_access_i | input | 1 | Qualifies an access to indices 8 to 12 while narrow_i is 1 |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Write data |
| link_en | input | 1 | Copy the program counter into the current bank's link register |
| stat_we | input | 1 | Write the status word |
| stat_wdata | input | 32 | New status word; bits [4:0] are the mode code |
| exc_en | input | 1 | Exception entry: save the status word and switch mode |
| exc_mode | input | 5 | Target mode code for exception entry |
| stat_rdata | output | 32 | Current status word |
| saved_rdata | output | 32 | Saved status word of the current mode, zero in user and system |

## Verification
The bank mapping is exercised with a fill pattern that encodes both the writing mode and the index in every value. User mode fills all of indices 0 to 14, and each privileged mode then fills only the indices it banks. Reading all fifteen indices back in every mode therefore tells a private copy apart from a shared one, and it would expose a wrong slot, a missing bank or a leak between modes. The program counter is written and read with set low bits under both alignment states, so write-side and read-side masking can be told apart. The tests also cover link capture under write conflicts, exception entry with and without a competing status write, hi-register gating, and a same-cycle read of the index being written, which separates a bypassed read from a registered one.

// File: rtl/rbank_pkg.sv
// Package rbank_pkg
// Shared mode codes, bank identifiers and sizes for the banked register file.
// Assumes a 5-bit mode field; any code outside the seven defined ones maps
// to the user bank.
package rbank_pkg;

    localparam int MODE_W    = 5;
    localparam int NUM_GPR   = 31;   // 16 shared + 7 fast-irq + 4 x 2 banked
    localparam int NUM_SAVED = 5;    // one saved status word per privileged bank

    localparam logic [MODE_W-1:0] M_USR = 5'b10000;
    localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M_UND = 5'b11011;
    localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    // Resolve a mode code to the storage bank it selects.
    function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
        case (m)
            M_FIQ:   return BK_FIQ;
            M_IRQ:   return BK_IRQ;
            M_SVC:   return BK_SVC;
            M_ABT:   return BK_ABT;
            M_UND:   return BK_UND;
            default: return BK_USR;
        endcase
    endfunction

endpackage

// File: rtl/bank_decode.sv
// Module bank_decode
// Maps a logical register index plus the current bank onto a physical
// general-register slot. Slot layout: 0..15 shared, 16..22 fast-irq 8..14,
// then pairs (13,14) for supervisor 23/24, abort 25/26, irq 27/28,
// undefined 29/30. Purely combinational.
module bank_decode
    import rbank_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int PHYS_W = 5
) (
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  idx,
    output logic [PHYS_W-1:0] phys
);
    localparam int FIQ_BASE  = 16;
    localparam int PAIR_BASE = 23;
    localparam logic [IDX_W-1:0] FIQ_LO = IDX_W'(8);
    localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(13);
    localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(14);

    logic [PHYS_W-1:0] pair_slot;

    // Pick the pair offset of a two-register bank.
    always_comb begin
        case (bank)
            BK_ABT:  pair_slot = PHYS_W'(1);
            BK_IRQ:  pair_slot = PHYS_W'(2);
            BK_UND:  pair_slot = PHYS_W'(3);
            default: pair_slot = PHYS_W'(0);
        endcase
    end

    // Select shared, fast-irq or paired slot.
    always_comb begin
        phys = PHYS_W'(idx);
        if (bank == BK_FIQ && idx >= FIQ_LO && idx <= LR_IDX) begin
            phys = PHYS_W'(FIQ_BASE) + PHYS_W'(idx - FIQ_LO);
        end else if (bank != BK_USR && bank != BK_FIQ &&
                     (idx == SP_IDX || idx == LR_IDX)) begin
            phys = PHYS_W'(PAIR_BASE) + (pair_slot << 1) + PHYS_W'(idx - SP_IDX);
        end
    end

endmodule

// File: rtl/gpr_array.sv
// Module gpr_array
// Physical general-register storage: two asynchronous read ports, a
// dedicated program-counter tap, and two write ports. When both write
// ports target one slot, port 1 (link capture) wins. Reads return the
// stored value (no write-to-read bypass).
module gpr_array #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 31,
    parameter int PHYS_W  = 5,
    parameter int PC_SLOT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHYS_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [PHYS_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] pc_data,
    input  logic              w0_en,
    input  logic [PHYS_W-1:0] w0_addr,
    input  logic [DATA_W-1:0] w0_data,
    input  logic              w1_en,
    input  logic [PHYS_W-1:0] w1_addr,
    input  logic [DATA_W-1:0] w1_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset; apply write port 0 then port 1 so port 1 wins a clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (w0_en && int'(w0_addr) < DEPTH) mem[w0_addr] <= w0_data;
            if (w1_en && int'(w1_addr) < DEPTH) mem[w1_addr] <= w1_data;
        end
    end

    // Asynchronous reads, guarded against unused slot codes.
    always_comb begin
        ra_data = (int'(ra_addr) < DEPTH) ? mem[ra_addr] : '0;
        rb_data = (int'(rb_addr) < DEPTH) ? mem[rb_addr] : '0;
        pc_data = mem[PC_SLOT];
    end

endmodule

// File: rtl/status_bank.sv
// Module status_bank
// Current status word plus five saved status words. Exception entry saves
// the current word into the target bank's slot and switches the mode field
// in one edge; it overrides a same-cycle status write. Reset enters
// supervisor mode.
module status_bank
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_we,
    input  logic [DATA_W-1:0] stat_wdata,
    input  logic              exc_en,
    input  logic [MODE_W-1:0] exc_mode,
    output logic [DATA_W-1:0] cur_stat,
    output logic [DATA_W-1:0] cur_saved,
    output bank_e             cur_bank
);
    localparam int SLOT_W = $clog2(NUM_SAVED);

    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] saved_q [NUM_SAVED];
    bank_e             tgt_bank;
    logic [SLOT_W-1:0] tgt_slot;
    logic [SLOT_W-1:0] cur_slot;

    // Decode current and target banks and their saved-word slots.
    always_comb begin
        cur_bank = bank_of(stat_q[MODE_W-1:0]);
        tgt_bank = bank_of(exc_mode);
        cur_slot = SLOT_W'(cur_bank) - SLOT_W'(1);
        tgt_slot = SLOT_W'(tgt_bank) - SLOT_W'(1);
    end

    // Status update: reset, exception entry, or plain status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= DATA_W'(M_SVC);
            for (int i = 0; i < NUM_SAVED; i++) saved_q[i] <= '0;
        end else if (exc_en) begin
            if (tgt_bank != BK_USR) saved_q[tgt_slot] <= stat_q;
            stat_q <= {stat_q[DATA_W-1:MODE_W], exc_mode};
        end else if (stat_we) begin
            stat_q <= stat_wdata;
        end
    end

    // Present the saved word of the current bank, zero for user/system.
    always_comb begin
        cur_stat  = stat_q;
        cur_saved = (cur_bank == BK_USR) ? '0 : saved_q[cur_slot];
    end

    AST_EXC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_en |=> cur_stat[MODE_W-1:0] == $past(exc_mode)) else $error("AST_EXC_MODE"); // R9
    AST_EXC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && bank_of(exc_mode) != BK_USR) |=> cur_saved == $past(cur_stat)) else $error("AST_EXC_SAVE"); // R9
    AST_NO_SAVED_USR: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_of(cur_stat[MODE_W-1:0]) == BK_USR) |-> cur_saved == '0) else $error("AST_NO_SAVED_USR"); // R5
    AST_STAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !exc_en) |=> cur_stat == $past(stat_wdata)) else $error("AST_STAT_WRITE"); // R12

endmodule

// File: rtl/banked_regfile.sv
// Module banked_regfile
// Mode-banked register file: 16 logical indices mapped onto 31 physical
// general registers by the mode held in the status word, plus status and
// saved-status words. Handles program counter alignment, link capture,
// exception entry and hi-register gating in compressed-instruction state.
// Assumes the caller resolves exception priority and instruction decode.
module banked_regfile
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_i,
    input  logic              hi_access_i,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic              stat_we,
    input  logic [DATA_W-1:0] stat_wdata,
    input  logic              exc_en,
    input  logic [MODE_W-1:0] exc_mode,
    output logic [DATA_W-1:0] stat_rdata,
    output logic [DATA_W-1:0] saved_rdata
);
    localparam int PHYS_W = $clog2(NUM_GPR);
    localparam int NPORT  = 4;               // read A, read B, write, link
    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(15);
    localparam logic [IDX_W-1:0] LR_IDX = IDX_W'(14);
    localparam logic [IDX_W-1:0] HI_LO  = IDX_W'(8);
    localparam logic [IDX_W-1:0] HI_HI  = IDX_W'(12);

    bank_e             bank;
    logic [IDX_W-1:0]  dec_idx  [NPORT];
    logic [PHYS_W-1:0] dec_phys [NPORT];
    logic [DATA_W-1:0] raw_a, raw_b, pc_raw, pc_mask, pc_val;
    logic              w0_en;
    logic [DATA_W-1:0] w0_data;

    // True when an index in 8..12 is blocked by compressed-state gating.
    function automatic logic hi_blocked(input logic [IDX_W-1:0] i,
                                        input logic nar, input logic hi);
        return nar && !hi && i >= HI_LO && i <= HI_HI;
    endfunction

    status_bank #(.DATA_W(DATA_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_we   (stat_we),
        .stat_wdata(stat_wdata),
        .exc_en    (exc_en),
        .exc_mode  (exc_mode),
        .cur_stat  (stat_rdata),
        .cur_saved (saved_rdata),
        .cur_bank  (bank)
    );

    // Collect the four logical indices that need bank resolution.
    always_comb begin
        dec_idx[0] = rd_a_idx;
        dec_idx[1] = rd_b_idx;
        dec_idx[2] = wr_idx;
        dec_idx[3] = LR_IDX;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_dec
        bank_decode #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_dec (
            .bank(bank),
            .idx (dec_idx[g]),
            .phys(dec_phys[g])
        );
    end

    // Alignment mask for the program counter under the current state.
    always_comb begin
        pc_mask = narrow_i ? ~DATA_W'(1) : ~DATA_W'(3);
        pc_val  = pc_raw & pc_mask;
    end

    // Qualify the general write; link capture overrides a write to index 14.
    always_comb begin
        w0_en   = wr_en && !hi_blocked(wr_idx, narrow_i, hi_access_i)
                        && !(link_en && wr_idx == LR_IDX);
        w0_data = (wr_idx == PC_IDX) ? (wr_data & pc_mask) : wr_data;
    end

    gpr_array #(.DATA_W(DATA_W), .DEPTH(NUM_GPR), .PHYS_W(PHYS_W), .PC_SLOT(15)) u_gpr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_addr(dec_phys[0]),
        .ra_data(raw_a),
        .rb_addr(dec_phys[1]),
        .rb_data(raw_b),
        .pc_data(pc_raw),
        .w0_en  (w0_en),
        .w0_addr(dec_phys[2]),
        .w0_data(w0_data),
        .w1_en  (link_en),
        .w1_addr(dec_phys[3]),
        .w1_data(pc_val)
    );

    // Shape read data: gate hi registers, align the program counter.
    always_comb begin
        if (hi_blocked(rd_a_idx, narrow_i, hi_access_i)) rd_a_data = '0;
        else if (rd_a_idx == PC_IDX)                     rd_a_data = raw_a & pc_mask;
        else                                             rd_a_data = raw_a;
        if (hi_blocked(rd_b_idx, narrow_i, hi_access_i)) rd_b_data = '0;
        else if (rd_b_idx == PC_IDX)                     rd_b_data = raw_b & pc_mask;
        else                                             rd_b_data = raw_b;
    end

    AST_PC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == PC_IDX) |-> (narrow_i ? rd_a_data[0] == 1'b0 : rd_a_data[1:0] == 2'b00)) else $error("AST_PC_ALIGN"); // R6
    AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_i && !hi_access_i && rd_b_idx >= HI_LO && rd_b_idx <= HI_HI) |-> rd_b_data == '0) else $error("AST_HI_GATED"); // R10
    AST_LINK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |-> (narrow_i ? pc_val[0] == 1'b0 : pc_val[1:0] == 2'b00)) else $error("AST_LINK_ALIGNED"); // R8

endmodule

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
    localparam logic [4:0] MU = 5'b10000, MF = 5'b10001, MI = 5'b10010,
                           MS = 5'b10011, MA = 5'b10111, MD = 5'b11011,
                           MY = 5'b11111, MX = 5'b00000;

    logic        clk = 0, rst_n = 0, narrow_i = 0, hi_access_i = 0;
    logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = 0, stat_wdata = 0;
    logic        wr_en = 0, link_en = 0, stat_we = 0, exc_en = 0;
    logic [4:0]  exc_mode = 0;
    logic [31:0] stat_rdata, saved_rdata;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    banked_regfile u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] val(input logic [4:0] m, input int idx);
        return 32'hC000_0000 | (32'(m) << 16) | 32'(idx);
    endfunction

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        rd_a_idx = 4'(idx); #1; v = rd_a_data;
    endtask

    task automatic set_stat(input logic [31:0] s);
        @(negedge clk); stat_we = 1; stat_wdata = s;
        @(negedge clk); stat_we = 0;
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [31:0] v;
        chk("R1 status", stat_rdata, 32'h13);
        chk("R1 saved", saved_rdata, 32'h0);
        for (int i = 0; i < 16; i++) begin rd(i, v); chk("R1 reg", v, 32'h0); end
    endtask

    // R2 R3 R4 R5: bank isolation and sharing
    task automatic t_banks();
        logic [31:0] v, e;
        logic [4:0] wm [5] = '{MF, MI, MS, MA, MD};
        logic [4:0] cm [8] = '{MU, MF, MI, MS, MA, MD, MY, MX};
        set_stat(32'(MU));
        for (int i = 0; i < 15; i++) wr(i, val(MU, i));
        foreach (wm[k]) begin
            set_stat(32'(wm[k]));
            if (wm[k] == MF) for (int i = 8; i < 15; i++) wr(i, val(MF, i));
            else begin wr(13, val(wm[k], 13)); wr(14, val(wm[k], 14)); end
        end
        foreach (cm[k]) begin
            set_stat(32'(cm[k]));
            for (int i = 0; i < 15; i++) begin
                rd(i, v);
                if (i < 8) e = val(MU, i);
                else if (cm[k] == MF) e = val(MF, i);
                else if (i >= 13 && cm[k] != MU && cm[k] != MY && cm[k] != MX) e = val(cm[k], i);
                else e = val(MU, i);
                if (cm[k] == MY || cm[k] == MX) chk("R5 user-alias", v, e);
                else if (i < 8) chk("R2 shared", v, e);
                else if (cm[k] == MF) chk("R3 fiq bank", v, e);
                else chk("R4 pair bank", v, e);
            end
            if (cm[k] == MU || cm[k] == MY || cm[k] == MX) chk("R5 saved zero", saved_rdata, 32'h0);
        end
        set_stat(32'(MS)); wr(15, 32'h4000);
        set_stat(32'(MF)); rd(15, v); chk("R2 pc shared", v, 32'h4000);
    endtask

    // R6 R7: program counter alignment
    task automatic t_pc();
        logic [31:0] v;
        narrow_i = 0; wr(15, 32'h1003); rd(15, v); chk("R7 word write", v, 32'h1000);
        narrow_i = 1; wr(15, 32'h2003); rd(15, v); chk("R7 half write", v, 32'h2002);
        narrow_i = 0; #1; rd(15, v); chk("R6 word read", v, 32'h2000);
        narrow_i = 1; #1; rd(15, v); chk("R6 half read", v, 32'h2002);
        rd_b_idx = 15; #1; chk("R6 port b", rd_b_data, 32'h2002);
        narrow_i = 0;
    endtask

    // R8: link capture
    task automatic t_link();
        logic [31:0] v;
        set_stat(32'(MI)); wr(15, 32'h3000);
        @(negedge clk); link_en = 1; @(negedge clk); link_en = 0;
        rd(14, v); chk("R8 irq lr", v, 32'h3000);
        set_stat(32'(MU)); rd(14, v); chk("R8 usr lr kept", v, val(MU, 14));
        @(negedge clk); link_en = 1; wr_en = 1; wr_idx = 14; wr_data = 32'hDEAD;
        @(negedge clk); link_en = 0; wr_en = 0;
        rd(14, v); chk("R8 link wins", v, 32'h3000);
        @(negedge clk); link_en = 1; wr_en = 1; wr_idx = 3; wr_data = 32'h55;
        @(negedge clk); link_en = 0; wr_en = 0;
        rd(3, v); chk("R8 other write kept", v, 32'h55);
        wr(14, val(MU, 14)); wr(3, val(MU, 3));
    endtask

    // R9 R12: exception entry
    task automatic t_exc();
        logic [31:0] v;
        set_stat(32'hF000_0010);
        @(negedge clk); exc_en = 1; exc_mode = MA;
        @(negedge clk); exc_en = 0;
        chk("R9 mode switch", stat_rdata, 32'hF000_0017);
        chk("R9 saved", saved_rdata, 32'hF000_0010);
        rd(13, v); chk("R9 new bank", v, val(MA, 13));
        @(negedge clk); exc_en = 1; exc_mode = MD; stat_we = 1; stat_wdata = 32'h1234_0010;
        @(negedge clk); exc_en = 0; stat_we = 0;
        chk("R12 exc wins", stat_rdata, 32'hF000_001B);
        chk("R9 und saved", saved_rdata, 32'hF000_0017);
        set_stat(32'h0000_0010); chk("R12 status write", stat_rdata, 32'h10);
    endtask

    // R10: hi-register gating
    task automatic t_narrow();
        logic [31:0] v;
        narrow_i = 1; hi_access_i = 0;
        rd(9, v); chk("R10 hi read gated", v, 32'h0);
        wr(9, 32'h99);
        rd(13, v); chk("R10 sp open", v, val(MU, 13));
        hi_access_i = 1; #1; rd(9, v); chk("R10 write ignored", v, val(MU, 9));
        wr(9, 32'h99); rd(9, v); chk("R10 hi write", v, 32'h99);
        narrow_i = 0; hi_access_i = 0;
    endtask

    // R11: no bypass
    task automatic t_bypass();
        @(negedge clk); wr_en = 1; wr_idx = 5; wr_data = 32'h5555; rd_a_idx = 5;
        #1; chk("R11 old value", rd_a_data, val(MU, 5));
        @(negedge clk); wr_en = 0; #1;
        chk("R11 new value", rd_a_data, 32'h5555);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        t_reset();
        t_banks();
        t_pc();
        t_link();
        t_exc();
        t_narrow();
        t_bypass();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule